// File: doc/BRIEF.md
# Programmable AND-OR Logic Array

This block is a field-configurable sum-of-products array. Every input bit is
offered to each product term twice, once as itself and once inverted. A term's
configuration row picks which of those literals it ANDs together. Each output
has a configuration column that picks which terms it ORs. Any term may feed
any number of outputs, so a term that several functions need is built once
and shared among them.

Configuration is held in registers and loaded one word per clock through an
address, data and write-enable port. A low range of addresses holds the AND
plane rows, one per product term. The range just above it holds the OR plane
columns, one per output. The array itself is combinational from the inputs
and the stored configuration, so a change on the inputs appears on the
outputs in the same cycle. A configuration write is seen on the outputs after
the clock edge that stores it. The default size is 4 inputs, 6 product terms
and 3 outputs. Any combinational function whose minimised form fits in the
available terms can be loaded.

Top module: `pla_logic_array`

## Requirements
- R1: While reset is asserted, and after it until the first write, every configuration bit is 0, so every output is 0 for every input pattern.
- R2: In an AND row, bit 2i selects input i in true form and bit 2i+1 selects input i in inverted form. A term is the AND of its selected literals.
- R3: A term whose row selects no literal evaluates to 1.
- R4: A term whose row selects both the true and the inverted form of one input evaluates to 0.
- R5: In an OR column, bit t connects term t. An output is the OR of its connected terms, and it is 0 whenever no term is 1.
- R6: An output whose column connects no term is 0 for every input pattern.
- R7: One term connected in several columns drives all of those outputs at once.
- R8: An address below NUM_TERM writes AND row number addr, taken from data bits [2*NUM_IN-1:0]. An address from NUM_TERM to NUM_TERM+NUM_OUT-1 writes OR column addr-NUM_TERM, taken from data bits [NUM_TERM-1:0]. Any higher address changes nothing.
- R9: A write is visible on the outputs after the rising edge on which the write enable is high. With the write enable low, address and data have no effect.
- R10: A write changes only the one row or column it addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rstN | input | 1 | Asynchronous reset, active low; clears all configuration |
| cfgWe | input | 1 | Configuration write enable |
| cfgAddr | input | $clog2(NUM_TERM+NUM_OUT+1) | Row or column address |
| cfgData | input | max(2*NUM_IN, NUM_TERM) | Configuration word |
| dataIn | input | NUM_IN | Logic inputs |
| dataOut | output | NUM_OUT | Sum-of-products outputs |

## Verification
The hardest behaviour to reach from the ports is the interaction of many
product terms: shared terms, self-cancelling terms and empty terms all loaded
at the same time. Only a full configuration can set that up. The stimulus
first loads one hand-built configuration that combines all three kinds of
term and checks it against a table of expected outputs. It then loads a
series of random full configurations and sweeps every input pattern after
each one, comparing the outputs with an independent software model. Writes
with the enable low and writes to unused addresses are placed between
sweeps, so that any stray change shows up on the outputs.

// File: rtl/pla_pkg.sv
package pla_pkg;
  // Width of the row/column index carried by the strobe struct.
  localparam int ROW_W = 8;

  typedef struct packed {
    logic             andWe;  // write one AND-plane row
    logic             orWe;   // write one OR-plane column
    logic [ROW_W-1:0] row;    // which row or column
  } cfgStrobe_t;
endpackage

// File: rtl/pla_cfg_ctrl.sv
module pla_cfg_ctrl
  import pla_pkg::*;
#(
  parameter int NUM_TERM = 6,
  parameter int NUM_OUT  = 3,
  parameter int ADDR_W   = 4
) (
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  output cfgStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] TERM_LIM = ADDR_W'(NUM_TERM);
  localparam logic [ADDR_W-1:0] END_LIM  = ADDR_W'(NUM_TERM + NUM_OUT);

  always_comb begin
    strobe = '0;
    if (cfgWe) begin
      if (cfgAddr < TERM_LIM) begin
        strobe.andWe = 1'b1;
        strobe.row   = ROW_W'(cfgAddr);
      end else if (cfgAddr < END_LIM) begin
        strobe.orWe = 1'b1;
        strobe.row  = ROW_W'(cfgAddr - TERM_LIM);
      end
    end
  end
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int NUM_IN   = 4,
  parameter int NUM_TERM = 6,
  localparam int LIT_W   = 2 * NUM_IN
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                we,
  input  logic [ROW_W-1:0]    row,
  input  logic [LIT_W-1:0]    cfgData,
  input  logic [NUM_IN-1:0]   dataIn,
  output logic [NUM_TERM-1:0] termVec
);
  logic [LIT_W-1:0] literals;
  logic [LIT_W-1:0] andRow [NUM_TERM];

  for (genvar i = 0; i < NUM_IN; i++) begin : g_lit
    assign literals[2*i]   = dataIn[i];
    assign literals[2*i+1] = ~dataIn[i];
  end

  for (genvar t = 0; t < NUM_TERM; t++) begin : g_term
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        andRow[t] <= '0;
      else if (we && row == ROW_W'(t))
        andRow[t] <= cfgData;
    end
    // unselected literals are forced to 1 so they do not affect the AND
    assign termVec[t] = &(literals | ~andRow[t]);
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane
  import pla_pkg::*;
#(
  parameter int NUM_TERM = 6,
  parameter int NUM_OUT  = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                we,
  input  logic [ROW_W-1:0]    row,
  input  logic [NUM_TERM-1:0] cfgData,
  input  logic [NUM_TERM-1:0] termVec,
  output logic [NUM_OUT-1:0]  dataOut
);
  logic [NUM_TERM-1:0] orCol [NUM_OUT];

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        orCol[o] <= '0;
      else if (we && row == ROW_W'(o))
        orCol[o] <= cfgData;
    end
    assign dataOut[o] = |(orCol[o] & termVec);
  end
endmodule

// File: rtl/pla_logic_array.sv
module pla_logic_array
  import pla_pkg::*;
#(
  parameter int  NUM_IN   = 4,
  parameter int  NUM_OUT  = 3,
  parameter int  NUM_TERM = 6,
  localparam int LIT_W    = 2 * NUM_IN,
  localparam int DATA_W   = (LIT_W > NUM_TERM) ? LIT_W : NUM_TERM,
  localparam int ADDR_W   = $clog2(NUM_TERM + NUM_OUT + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [DATA_W-1:0]  cfgData,
  input  logic [NUM_IN-1:0]  dataIn,
  output logic [NUM_OUT-1:0] dataOut
);
  cfgStrobe_t          strobe;
  logic [NUM_TERM-1:0] termVec;

  pla_cfg_ctrl #(.NUM_TERM(NUM_TERM), .NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)) ctrl_i (
    .cfgWe  (cfgWe),
    .cfgAddr(cfgAddr),
    .strobe (strobe)
  );

  pla_and_plane #(.NUM_IN(NUM_IN), .NUM_TERM(NUM_TERM)) and_i (
    .clk    (clk),
    .rstN   (rstN),
    .we     (strobe.andWe),
    .row    (strobe.row),
    .cfgData(cfgData[LIT_W-1:0]),
    .dataIn (dataIn),
    .termVec(termVec)
  );

  pla_or_plane #(.NUM_TERM(NUM_TERM), .NUM_OUT(NUM_OUT)) or_i (
    .clk    (clk),
    .rstN   (rstN),
    .we     (strobe.orWe),
    .row    (strobe.row),
    .cfgData(cfgData[NUM_TERM-1:0]),
    .termVec(termVec),
    .dataOut(dataOut)
  );
endmodule

// File: rtl/pla_logic_array_chk.sv
module pla_logic_array_chk #(
  parameter int NUM_IN   = 4,
  parameter int NUM_OUT  = 3,
  parameter int NUM_TERM = 6,
  parameter int ADDR_W   = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                cfgWe,
  input logic [ADDR_W-1:0]   cfgAddr,
  input logic [NUM_IN-1:0]   dataIn,
  input logic [NUM_TERM-1:0] termVec,
  input logic [NUM_OUT-1:0]  dataOut
);
  localparam logic [ADDR_W-1:0] END_LIM = ADDR_W'(NUM_TERM + NUM_OUT);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> dataOut == '0);

  // R9
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |=> (!$stable(dataIn) || $stable(dataOut)));

  // R8
  out_of_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgAddr >= END_LIM) |=> (!$stable(dataIn) || $stable(dataOut)));

  // R5
  no_term_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    termVec == '0 |-> dataOut == '0);
endmodule

bind pla_logic_array pla_logic_array_chk #(
  .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .NUM_TERM(NUM_TERM), .ADDR_W(ADDR_W)
) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .cfgWe  (cfgWe),
  .cfgAddr(cfgAddr),
  .dataIn (dataIn),
  .termVec(termVec),
  .dataOut(dataOut)
);

// File: tb/pla_logic_array_tb_top.sv
module pla_logic_array_tb_top;
  localparam int NI = 4;
  localparam int NO = 3;
  localparam int NT = 6;
  localparam int DW = 8;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWe = 1'b0;
  logic [AW-1:0] cfgAddr = '0;
  logic [DW-1:0] cfgData = '0;
  logic [NI-1:0] dataIn = '0;
  logic [NO-1:0] dataOut;

  int checks = 0;
  int errors = 0;

  logic [2*NI-1:0] mAnd [NT];
  logic [NT-1:0]   mOr  [NO];

  // {input pattern, expected outputs} for the hand-built configuration
  localparam logic [6:0] VEC [16] = '{
    {4'd0, 3'b011}, {4'd1, 3'b000}, {4'd2, 3'b000}, {4'd3, 3'b001},
    {4'd4, 3'b011}, {4'd5, 3'b010}, {4'd6, 3'b010}, {4'd7, 3'b011},
    {4'd8, 3'b011}, {4'd9, 3'b010}, {4'd10,3'b010}, {4'd11,3'b011},
    {4'd12,3'b011}, {4'd13,3'b010}, {4'd14,3'b010}, {4'd15,3'b011}};

  pla_logic_array dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .dataIn(dataIn), .dataOut(dataOut)
  );

  always #2 clk = ~clk;

  function automatic logic [NO-1:0] model(logic [NI-1:0] x);
    logic [NO-1:0] r = '0;
    for (int o = 0; o < NO; o++)
      for (int t = 0; t < NT; t++) begin
        logic term = 1'b1;
        for (int i = 0; i < NI; i++) begin
          if (mAnd[t][2*i] && !x[i]) term = 1'b0;
          if (mAnd[t][2*i+1] && x[i]) term = 1'b0;
        end
        if (mOr[o][t] && term) r[o] = 1'b1;
      end
    return r;
  endfunction

  task automatic check(logic [NO-1:0] got, logic [NO-1:0] exp, string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: in=%h got=%b expected=%b", req, dataIn, got, exp);
    end
  endtask

  task automatic cfgWrite(int addr, logic [DW-1:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = AW'(addr); cfgData = data;
    if (addr < NT) mAnd[addr] = data;
    else if (addr < NT + NO) mOr[addr-NT] = data[NT-1:0];
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic sweep(string req);
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      dataIn = NI'(v);
      #1 check(dataOut, model(dataIn), req);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int t = 0; t < NT; t++) mAnd[t] = '0;
    for (int o = 0; o < NO; o++) mOr[o] = '0;

    // R1: outputs held at 0 during and after reset
    for (int v = 0; v < 16; v += 5) begin
      @(negedge clk); dataIn = NI'(v);
      #1 check(dataOut, '0, "R1 in reset");
    end
    @(negedge clk); rstN = 1'b1;
    sweep("R1 after reset");

    // R9: enable low, address and data ignored
    @(negedge clk); cfgAddr = AW'(NT); cfgData = '1; cfgWe = 1'b0;
    @(negedge clk);
    sweep("R9 enable low");

    // hand-built configuration (R2 R4 R7): a&b, ~a&~b, c&~d, d, empty, a&~a
    cfgWrite(0, 8'h05); cfgWrite(1, 8'h0A); cfgWrite(2, 8'h90);
    cfgWrite(3, 8'h40); cfgWrite(4, 8'h00); cfgWrite(5, 8'h03);
    cfgWrite(6, 8'b000011); cfgWrite(7, 8'b001110); cfgWrite(8, 8'b100000);
    // R2 R4 R7: table walk; term 1 shared by outputs 0 and 1
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); dataIn = VEC[k][6:3];
      #1 check(dataOut, VEC[k][2:0], "R2 R4 R7 table");
    end

    // R3: output 2 connected to the empty term only
    cfgWrite(8, 8'b010000);
    sweep("R3 empty term");
    for (int v = 0; v < 16; v += 3) begin
      @(negedge clk); dataIn = NI'(v);
      #1 check(dataOut[2], 1'b1, "R3 direct");
    end

    // R6: output 2 with nothing connected
    cfgWrite(8, 8'h00);
    sweep("R6 empty output");

    // R8: addresses beyond the last column
    cfgWrite(9, 8'hFF); cfgWrite(15, 8'hFF);
    sweep("R8 out of range");

    // R10: rewrite one row only
    cfgWrite(3, 8'h20);
    sweep("R10 single row");

    // R5 R2: random full configurations vs model
    for (int n = 0; n < 25; n++) begin
      for (int a = 0; a < NT + NO; a++) cfgWrite(a, DW'($urandom));
      sweep("R5 random");
      cfgWrite(NT + ($urandom % NO), DW'($urandom));
      sweep("R10 random column");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule